// File: doc/BRIEF.md
# E1 Bus Timing Generator

This block turns one fast clock-enable into the complete family of E1 backplane timing signals: five square-wave bus clocks at 2.048, 4.096, 8.192, 16.384 and 32.768 MHz, four active-low frame pulses (one per 2, 8, 16 and 32 MHz bus), and a receive-sync and a transmit-sync strobe. Every output is decoded from a single frame-position counter that wraps once every 125 µs. As a result, all rising clock edges and all frame pulses keep a fixed phase to the 8 kHz frame that goes with the 8 MHz bus.

A 32.768 MHz square wave with 50% duty needs two enable phases per period. The enable from the oscillator therefore runs at 65.536 MHz nominal, and one frame is 8192 enables. The counter advances only on cycles where `tick_en` is high, so the system clock may run at any rate above the enable rate.

A two-bit rate select also drives an auxiliary clock output. For three of the four codes it copies the 2.048 MHz bus clock. For the 1.544 MHz reference code it passes through the T1 bus clock, which comes from a separate divider.

Top module: `e1_bus_timing_gen`

## Requirements
- R1: The frame position starts at 0 after reset and advances by one only on clock edges where `tick_en` is high. It wraps from 2^FRAME_W-1 (default 8191) to 0.
- R2: Bus clock k (k=0 is `clk32_o`, 1 `clk16_o`, 2 `clk8_o`, 3 `clk4_o`, 4 `clk2_o`) is high exactly when bit k of the frame position is 0. Each clock therefore has 50% duty, and all clocks rise together at position 0.
- R3: Each frame pulse is low for one period of its own bus clock, centred on the wrap. It is low when the position is at or above 2^FRAME_W-h, or below h once the first wrap has happened. h is 1 for `fp32_n`, 2 for `fp16_n`, 4 for `fp8_n` and 16 for `fp2_n`.
- R4: After reset, no frame pulse goes low before the position reaches its pre-wrap window. `fp32_n` first goes low after exactly 2^FRAME_W-1 enables.
- R5: `rx_sync` is high only while the position equals RX_POS (default 4), and `tx_sync` is high only while it equals TX_POS (default 8188). Each strobe lasts one enable period.
- R6: Reset is synchronous and active high, and it overrides `tick_en`. While reset is applied, all clocks read high, all frame pulses read high, both strobes read low, `aux_t1_mode` reads 0 and `aux_clk` reads high.
- R7: With `rate_sel` = 2'b10 (1.544 MHz reference), `aux_t1_mode` is 1 and `aux_clk` equals `t1_clk` as sampled on the previous clock edge. With 2'b00, 2'b01 or 2'b11, `aux_t1_mode` is 0 and `aux_clk` equals `clk2_o`.
- R8: While `tick_en` stays low, every bus clock, frame pulse and strobe output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Fast enable from the oscillator, nominal 65.536 MHz |
| rate_sel | input | 2 | Reference-rate select that picks the auxiliary clock |
| t1_clk | input | 1 | 1.544 MHz T1 bus clock from the T1 divider |
| clk32_o | output | 1 | 32.768 MHz bus clock |
| clk16_o | output | 1 | 16.384 MHz bus clock |
| clk8_o | output | 1 | 8.192 MHz bus clock |
| clk4_o | output | 1 | 4.096 MHz bus clock |
| clk2_o | output | 1 | 2.048 MHz bus clock |
| fp32_n | output | 1 | Frame pulse for the 32 MHz bus, active low |
| fp16_n | output | 1 | Frame pulse for the 16 MHz bus, active low |
| fp8_n | output | 1 | Frame pulse for the 8 MHz bus, active low |
| fp2_n | output | 1 | Frame pulse for the 2 MHz bus, active low |
| rx_sync | output | 1 | Receive-sync strobe |
| tx_sync | output | 1 | Transmit-sync strobe |
| aux_clk | output | 1 | Auxiliary clock selected by `rate_sel` |
| aux_t1_mode | output | 1 | High when the auxiliary output carries the T1 clock |

## Verification
A wrong frame position shows at the bus clock pins within one enable, because the five clocks are simply the inverted low bits of that position. An error in the upper bits, or in the flag that marks the first wrap, only shows once the frame pulses and strobes come due. That can take up to a full frame of 8192 enables, so the stimulus table samples positions on both sides of the first and second wraps and at both strobe positions. Stepping with an irregular enable pattern shows any advance on a non-enable cycle as a count mismatch at the next sample.

// File: rtl/e1tg_pkg.sv
package e1tg_pkg;

  localparam int unsigned N_BUS_CLK = 5;
  localparam int unsigned N_FRAME   = 4;

  typedef enum logic [1:0] {
    REF_19M44 = 2'b00,
    REF_8K    = 2'b01,
    REF_1M544 = 2'b10,
    REF_2M048 = 2'b11
  } ref_rate_e;

  // Frame pulse j uses counter bit 0,1,2 for j=0..2 and bit 4 for j=3
  function automatic int unsigned fp_clock_bit(input int unsigned j);
    return (j < 3) ? j : j + 1;
  endfunction

  // True when a pulse of half-width 'half' is active at position 'pos'
  function automatic logic in_frame_window(input int unsigned pos,
                                           input int unsigned half,
                                           input int unsigned len,
                                           input logic        armed);
    return (pos >= len - half) || (armed && (pos < half));
  endfunction

endpackage

// File: rtl/e1tg_frame_cnt.sv
module e1tg_frame_cnt #(
  parameter int unsigned FRAME_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  output logic [FRAME_W-1:0] cnt_q,
  output logic [FRAME_W-1:0] cnt_nxt,
  output logic               armed_q,
  output logic               armed_nxt
);

  localparam logic [FRAME_W-1:0] LAST_POS = '1;

  always_comb begin
    cnt_nxt   = cnt_q;
    armed_nxt = armed_q;
    if (rst) begin
      cnt_nxt   = '0;
      armed_nxt = 1'b0;
    end else if (tick) begin
      cnt_nxt = cnt_q + 1'b1;
      if (cnt_q == LAST_POS) armed_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    cnt_q   <= cnt_nxt;
    armed_q <= armed_nxt;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == LAST_POS) |=> (cnt_q == '0 && armed_q)); // R1

  AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q != LAST_POS) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/e1tg_bus_clk.sv
module e1tg_bus_clk #(
  parameter int unsigned FRAME_W = 13,
  parameter int unsigned N_CLK   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [FRAME_W-1:0] cnt_nxt,
  output logic [N_CLK-1:0]   clk_q
);

  generate
    for (genvar k = 0; k < N_CLK; k++) begin : g_clk
      always_ff @(posedge clk) begin
        clk_q[k] <= ~cnt_nxt[k];
      end
    end
  endgenerate

  AST_FAST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> (clk_q[0] != $past(clk_q[0]))); // R2

  AST_CLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(clk_q)); // R8

endmodule

// File: rtl/e1tg_frame_pulse.sv
module e1tg_frame_pulse
  import e1tg_pkg::*;
#(
  parameter int unsigned FRAME_W = 13,
  parameter int unsigned N_FP    = 4,
  parameter int unsigned RX_POS  = 4,
  parameter int unsigned TX_POS  = 8188
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [FRAME_W-1:0] cnt_nxt,
  input  logic               armed_nxt,
  output logic [N_FP-1:0]    fp_n,
  output logic               rx_q,
  output logic               tx_q
);

  localparam int unsigned       FRAME_LEN = 1 << FRAME_W;
  localparam logic [FRAME_W-1:0] RX_AT    = RX_POS[FRAME_W-1:0];
  localparam logic [FRAME_W-1:0] TX_AT    = TX_POS[FRAME_W-1:0];

  generate
    for (genvar j = 0; j < N_FP; j++) begin : g_fp
      localparam int unsigned HALF = 1 << fp_clock_bit(j);
      always_ff @(posedge clk) begin
        fp_n[j] <= ~in_frame_window(int'(cnt_nxt), HALF, FRAME_LEN, armed_nxt);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    rx_q <= (cnt_nxt == RX_AT);
    tx_q <= (cnt_nxt == TX_AT);
  end

  AST_RX_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    (tick && rx_q) |=> !rx_q); // R5

  AST_TX_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    (tick && tx_q) |=> !tx_q); // R5

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    $countones({rx_q, tx_q}) <= 1); // R5

endmodule

// File: rtl/e1tg_aux_sel.sv
module e1tg_aux_sel
  import e1tg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       t1_clk,
  input  logic       clk2_nxt,
  output logic       aux_clk,
  output logic       aux_t1_mode
);

  logic pick_t1;
  assign pick_t1 = (ref_rate_e'(rate_sel) == REF_1M544);

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_t1_mode <= 1'b0;
      aux_clk     <= clk2_nxt;
    end else begin
      aux_t1_mode <= pick_t1;
      aux_clk     <= pick_t1 ? t1_clk : clk2_nxt;
    end
  end

  AST_AUX_FOLLOWS_T1: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == 2'b10) |=> (aux_t1_mode && aux_clk == $past(t1_clk))); // R7

  AST_AUX_E1_MODE: assert property (@(posedge clk) disable iff (rst)
    (rate_sel != 2'b10) |=> !aux_t1_mode); // R7

endmodule

// File: rtl/e1_bus_timing_gen.sv
module e1_bus_timing_gen
  import e1tg_pkg::*;
#(
  parameter int unsigned FRAME_W = 13,
  parameter int unsigned RX_POS  = 4,
  parameter int unsigned TX_POS  = 8188
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic [1:0] rate_sel,
  input  logic       t1_clk,
  output logic       clk32_o,
  output logic       clk16_o,
  output logic       clk8_o,
  output logic       clk4_o,
  output logic       clk2_o,
  output logic       fp32_n,
  output logic       fp16_n,
  output logic       fp8_n,
  output logic       fp2_n,
  output logic       rx_sync,
  output logic       tx_sync,
  output logic       aux_clk,
  output logic       aux_t1_mode
);

  localparam int unsigned        FRAME_LEN = 1 << FRAME_W;
  localparam int unsigned        CLK2_BIT  = N_BUS_CLK - 1;
  localparam logic [FRAME_W-1:0] FP32_START = FRAME_W'(FRAME_LEN - 1);

  logic [FRAME_W-1:0]   cnt_q;
  logic [FRAME_W-1:0]   cnt_nxt;
  logic                 armed_q;
  logic                 armed_nxt;
  logic [N_BUS_CLK-1:0] bus_clk;
  logic [N_FRAME-1:0]   fp_vec_n;
  logic                 rx_q;
  logic                 tx_q;

  e1tg_frame_cnt #(.FRAME_W(FRAME_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_en),
    .cnt_q     (cnt_q),
    .cnt_nxt   (cnt_nxt),
    .armed_q   (armed_q),
    .armed_nxt (armed_nxt)
  );

  e1tg_bus_clk #(.FRAME_W(FRAME_W), .N_CLK(N_BUS_CLK)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_en),
    .cnt_nxt (cnt_nxt),
    .clk_q   (bus_clk)
  );

  e1tg_frame_pulse #(
    .FRAME_W (FRAME_W),
    .N_FP    (N_FRAME),
    .RX_POS  (RX_POS),
    .TX_POS  (TX_POS)
  ) u_fp (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_en),
    .cnt_nxt   (cnt_nxt),
    .armed_nxt (armed_nxt),
    .fp_n      (fp_vec_n),
    .rx_q      (rx_q),
    .tx_q      (tx_q)
  );

  e1tg_aux_sel u_aux (
    .clk         (clk),
    .rst         (rst),
    .rate_sel    (rate_sel),
    .t1_clk      (t1_clk),
    .clk2_nxt    (~cnt_nxt[CLK2_BIT]),
    .aux_clk     (aux_clk),
    .aux_t1_mode (aux_t1_mode)
  );

  assign clk32_o = bus_clk[0];
  assign clk16_o = bus_clk[1];
  assign clk8_o  = bus_clk[2];
  assign clk4_o  = bus_clk[3];
  assign clk2_o  = bus_clk[4];
  assign fp32_n  = fp_vec_n[0];
  assign fp16_n  = fp_vec_n[1];
  assign fp8_n   = fp_vec_n[2];
  assign fp2_n   = fp_vec_n[3];
  assign rx_sync = rx_q;
  assign tx_sync = tx_q;

  AST_NO_EARLY_FP: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && cnt_q < FP32_START) |-> fp32_n); // R4

  AST_EDGES_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> (&bus_clk)); // R2

  AST_FP_NESTED: assert property (@(posedge clk) disable iff (rst)
    (!fp32_n) |-> (!fp16_n && !fp8_n && !fp2_n)); // R3

  AST_AUX_MATCH_E1: assert property (@(posedge clk) disable iff (rst)
    (!aux_t1_mode) |-> (aux_clk == clk2_o)); // R7

endmodule

// File: tb/e1_bus_timing_gen_tb.sv
module e1_bus_timing_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       t1_clk = 1'b0;
  logic clk32_o, clk16_o, clk8_o, clk4_o, clk2_o;
  logic fp32_n, fp16_n, fp8_n, fp2_n;
  logic rx_sync, tx_sync, aux_clk, aux_t1_mode;

  int n_tests = 0;
  int n_fail  = 0;
  int ticks   = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  e1_bus_timing_gen dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rate_sel(rate_sel), .t1_clk(t1_clk),
    .clk32_o(clk32_o), .clk16_o(clk16_o), .clk8_o(clk8_o), .clk4_o(clk4_o), .clk2_o(clk2_o),
    .fp32_n(fp32_n), .fp16_n(fp16_n), .fp8_n(fp8_n), .fp2_n(fp2_n),
    .rx_sync(rx_sync), .tx_sync(tx_sync), .aux_clk(aux_clk), .aux_t1_mode(aux_t1_mode)
  );

  // n: enables since reset; clks {2,4,8,16,32}; fp {2,8,16,32}; rx; tx
  typedef struct packed {
    int         n;
    logic [4:0] clks;
    logic [3:0] fp;
    logic       rx;
    logic       tx;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1,     5'b11110, 4'b1111, 1'b0, 1'b0},
    '{4,     5'b11011, 4'b1111, 1'b1, 1'b0},
    '{19,    5'b01100, 4'b1111, 1'b0, 1'b0},
    '{8187,  5'b00100, 4'b0111, 1'b0, 1'b0},
    '{8188,  5'b00011, 4'b0011, 1'b0, 1'b1},
    '{8190,  5'b00001, 4'b0001, 1'b0, 1'b0},
    '{8191,  5'b00000, 4'b0000, 1'b0, 1'b0},
    '{8192,  5'b11111, 4'b0000, 1'b0, 1'b0},
    '{8193,  5'b11110, 4'b0001, 1'b0, 1'b0},
    '{8195,  5'b11100, 4'b0011, 1'b0, 1'b0},
    '{8196,  5'b11011, 4'b0111, 1'b1, 1'b0},
    '{8208,  5'b01111, 4'b1111, 1'b0, 1'b0},
    '{16383, 5'b00000, 4'b0000, 1'b0, 1'b0},
    '{16384, 5'b11111, 4'b0000, 1'b0, 1'b0},
    '{16387, 5'b11100, 4'b0011, 1'b0, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick_to(input int n);
    while (ticks < n) begin
      @(negedge clk);
      tick_en = ((cyc % 5) != 2);
      cyc++;
      @(posedge clk);
      if (tick_en) ticks++;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick_en = 1'b0;
    ticks = 0;
  endtask

  task automatic check_reset_state(input string tag);
    check("R6", {tag, " clocks"}, {clk2_o, clk4_o, clk8_o, clk16_o, clk32_o}, 5'b11111);
    check("R6", {tag, " frames"}, {fp2_n, fp8_n, fp16_n, fp32_n}, 4'b1111);
    check("R6", {tag, " strobes"}, {rx_sync, tx_sync}, 2'b00);
    check("R6", {tag, " aux"}, {aux_t1_mode, aux_clk}, 2'b01);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R6: reset applied with tick_en high, sampled before any enable
    do_reset();
    check_reset_state("initial");

    // R1 R2 R3 R4 R5: walk the stimulus table with an irregular enable
    for (int i = 0; i < NV; i++) begin
      tick_to(VEC[i].n);
      check("R2", $sformatf("clocks at n=%0d", VEC[i].n),
            {clk2_o, clk4_o, clk8_o, clk16_o, clk32_o}, VEC[i].clks);
      check("R3", $sformatf("frames at n=%0d", VEC[i].n),
            {fp2_n, fp8_n, fp16_n, fp32_n}, VEC[i].fp);
      check("R5", $sformatf("strobes at n=%0d", VEC[i].n),
            {rx_sync, tx_sync}, {VEC[i].rx, VEC[i].tx});
    end

    // R8: no enable for a stretch, outputs hold (position 3 of frame 3)
    repeat (12) @(negedge clk);
    check("R8", "clocks idle", {clk2_o, clk4_o, clk8_o, clk16_o, clk32_o}, 5'b11100);
    check("R8", "frames idle", {fp2_n, fp8_n, fp16_n, fp32_n}, 4'b0011);
    check("R8", "strobes idle", {rx_sync, tx_sync}, 2'b00);

    // R7: E1 codes copy clk2_o (high here)
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      rate_sel = 2'(s);
      t1_clk = 1'b0;
      @(negedge clk);
      check("R7", $sformatf("mode sel=%0d", s), aux_t1_mode, 1'b0);
      check("R7", $sformatf("aux=clk2 sel=%0d", s), aux_clk, clk2_o);
      check("R7", $sformatf("aux level sel=%0d", s), aux_clk, 1'b1);
    end

    // R7: T1 code passes t1_clk with one edge of latency
    rate_sel = 2'b10;
    for (int k = 0; k < 4; k++) begin
      t1_clk = k[0];
      @(negedge clk);
      check("R7", $sformatf("t1 mode step %0d", k), aux_t1_mode, 1'b1);
      check("R7", $sformatf("t1 follow step %0d", k), aux_clk, k[0]);
    end

    // R7: back to an E1 code while clk2_o is low
    rate_sel = 2'b01;
    tick_to(16400);
    @(negedge clk);
    check("R7", "clk2 low at pos 16", clk2_o, 1'b0);
    check("R7", "aux returns to clk2", aux_clk, clk2_o);
    check("R7", "mode cleared", aux_t1_mode, 1'b0);

    // R6: reset mid-frame returns to start; R4: first fp32 low only at 8191
    do_reset();
    check_reset_state("mid-frame");
    tick_to(8175);
    check("R4", "fp2 before window", fp2_n, 1'b1);
    tick_to(8190);
    check("R4", "fp32 high at 8190", fp32_n, 1'b1);
    tick_to(8191);
    check("R4", "fp32 low at 8191", fp32_n, 1'b0);
    check("R1", "wrap pending clocks", {clk2_o, clk4_o, clk8_o, clk16_o, clk32_o}, 5'b00000);
    tick_to(8192);
    check("R1", "wrap clocks", {clk2_o, clk4_o, clk8_o, clk16_o, clk32_o}, 5'b11111);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule